// File: doc/BRIEF.md
# Internal Error Reporting Controller

This block sits behind a port's internal error detectors. Every detected error event is logged in a status register. An error that is not masked is then reported as uncorrectable or as correctable, according to a severity bit held for each error. Three function views see the same errors: a bridge view, a non-transparent view and a DMA view. Each view has its own mask register and its own pair of sticky summary bits, one uncorrectable and one correctable. Each view also has its own one-cycle report pulse for each class. A message generator downstream turns those pulses into the actual error messages.

A summary bit suppresses further reports of its class in its view until software clears it. Logging goes on regardless. Software can emulate errors through a self-clearing inject register. Emulated errors reach only the bridge view. A single global enable bit gates every report. The register port is a plain single-cycle write strobe with a combinational read. There is no streaming data path, so there is no valid/ready handshake and no back-pressure. Error inputs are single-cycle event pulses.

Top module: `ierr_report_ctrl`

## Requirements
- R1: Every error event, whether from `err_evt` or from injection, sets its bit in the status register (address 0) on the clock edge that samples it. This happens regardless of masks, the global enable and the summary bits.
- R2: Writing the status register clears each bit written as one and leaves each bit written as zero unchanged. If an event and a clear hit the same bit in the same cycle, the bit ends up set.
- R3: Severity register (address 1) bit i selects the class of error i: 1 means uncorrectable and 0 means correctable.
- R4: Mask registers at address 4 (bridge), 5 (non-transparent) and 6 (DMA) block reporting of bit i in that view only when bit i is 1.
- R5: An unmasked, enabled error whose class summary bit is clear does two things on the edge that samples it. It sets that summary bit, and it raises the view's report pulse for that class for exactly one cycle. Report vector bit 0 is bridge, bit 1 is non-transparent and bit 2 is DMA.
- R6: While a view's summary bit of one class is set, further errors of that class raise no report in that view. Reports of the other class are unaffected.
- R7: The summary register (address 7) holds bit 2f for the uncorrectable summary of view f and bit 2f+1 for the correctable summary. Writing one clears a bit. If a clear and a new error of the same class arrive in the same cycle, the error reports and the summary bit stays set.
- R8: Writing a one to the inject register (address 3) makes that error occur one cycle later, for a single cycle. It is logged, and it is reported only in the bridge view. The inject register always reads zero.
- R9: With the global enable (address 2, bit 0) at 0, no report pulses fire and no summary bits are set.
- R10: After reset all registers read zero and all report outputs are low.
- R11: The severity, control and mask registers read back the value last written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_evt | input | NERR | Single-cycle error event pulses from the detectors |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | NERR | Register write data |
| reg_rdata | output | NERR | Combinational read data for `reg_addr` |
| rpt_unc | output | 3 | Uncorrectable report pulse per view |
| rpt_cor | output | 3 | Correctable report pulse per view |

## Verification
The bench drives a clear and an error at the same bit in the same cycle, once on the status register and once on the summary register. A design in which the clear wins would lose the logged error, or would set the summary bit without ever reporting. It sends a second uncorrectable error while that summary is set and checks that nothing is reported while the status bit still logs. It also sends a correctable error during that time, which must still report, so a design that shares suppression across classes would show up. An injected error must report on the bridge view only and for a single cycle, which exposes injection that leaks into the other views or that repeats. A mask on one view must leave the other two views reporting.

// File: rtl/ierr_pkg.sv
package ierr_pkg;
  localparam int NFN = 3;
  localparam int FN_BR = 0;
  localparam int FN_NT = 1;
  localparam int FN_DMA = 2;

  typedef enum logic [2:0] {
    A_STATUS = 3'd0,
    A_SEV    = 3'd1,
    A_CTRL   = 3'd2,
    A_INJ    = 3'd3,
    A_MSK_BR = 3'd4,
    A_MSK_NT = 3'd5,
    A_MSK_DM = 3'd6,
    A_SUM    = 3'd7
  } ierr_addr_e;
endpackage

// File: rtl/ierr_regs.sv
module ierr_regs
  import ierr_pkg::*;
#(
  parameter int NERR = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NERR-1:0]           err_evt,
  input  logic                      reg_we,
  input  logic [2:0]                reg_addr,
  input  logic [NERR-1:0]           reg_wdata,
  output logic [NERR-1:0]           reg_rdata,
  input  logic [NFN-1:0]            sum_unc,
  input  logic [NFN-1:0]            sum_cor,
  output logic [NERR-1:0]           status,
  output logic [NERR-1:0]           sev,
  output logic [NERR-1:0]           inj_q,
  output logic                      glb_en,
  output logic [NFN-1:0][NERR-1:0]  mask,
  output logic [NFN-1:0]            clr_unc,
  output logic [NFN-1:0]            clr_cor
);
  localparam int SUMW = 2 * NFN;

  logic wr_status, wr_sev, wr_ctrl, wr_inj, wr_sum;
  logic [NERR-1:0] status_clr;
  logic [SUMW-1:0] sum_vec;

  assign wr_status = reg_we && (reg_addr == A_STATUS);
  assign wr_sev    = reg_we && (reg_addr == A_SEV);
  assign wr_ctrl   = reg_we && (reg_addr == A_CTRL);
  assign wr_inj    = reg_we && (reg_addr == A_INJ);
  assign wr_sum    = reg_we && (reg_addr == A_SUM);
  assign status_clr = wr_status ? reg_wdata : '0;

  // Status: clear by write-one; new events are OR-ed in last so they win.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      sev    <= '0;
      glb_en <= 1'b0;
      inj_q  <= '0;
    end else begin
      status <= (status & ~status_clr) | err_evt | inj_q;
      if (wr_sev) sev <= reg_wdata;
      if (wr_ctrl) glb_en <= reg_wdata[0];
      inj_q <= wr_inj ? reg_wdata : '0;
    end
  end

  for (genvar f = 0; f < NFN; f++) begin : g_fn
    localparam logic [2:0] MADDR = 3'(int'(A_MSK_BR) + f);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask[f] <= '0;
      else if (reg_we && reg_addr == MADDR) mask[f] <= reg_wdata;
    end
    assign clr_unc[f]     = wr_sum & reg_wdata[2*f];
    assign clr_cor[f]     = wr_sum & reg_wdata[2*f+1];
    assign sum_vec[2*f]   = sum_unc[f];
    assign sum_vec[2*f+1] = sum_cor[f];
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_STATUS: reg_rdata = status;
      A_SEV:    reg_rdata = sev;
      A_CTRL:   reg_rdata[0] = glb_en;
      A_INJ:    reg_rdata = '0;
      A_MSK_BR: reg_rdata = mask[FN_BR];
      A_MSK_NT: reg_rdata = mask[FN_NT];
      A_MSK_DM: reg_rdata = mask[FN_DMA];
      A_SUM:    reg_rdata[SUMW-1:0] = sum_vec;
      default:  reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/ierr_fn_report.sv
module ierr_fn_report #(
  parameter int NERR = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NERR-1:0] evt,
  input  logic [NERR-1:0] mask,
  input  logic [NERR-1:0] sev,
  input  logic            glb_en,
  input  logic            clr_unc,
  input  logic            clr_cor,
  output logic            sum_unc,
  output logic            sum_cor,
  output logic            rpt_unc,
  output logic            rpt_cor
);
  logic [NERR-1:0] hit;
  logic unc_hit, cor_hit, unc_hold, cor_hold;

  assign hit      = evt & ~mask & {NERR{glb_en}};
  assign unc_hit  = |(hit & sev);
  assign cor_hit  = |(hit & ~sev);
  // Summary after this cycle's software clear; a pending clear re-opens reporting.
  assign unc_hold = sum_unc & ~clr_unc;
  assign cor_hold = sum_cor & ~clr_cor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum_unc <= 1'b0;
      sum_cor <= 1'b0;
      rpt_unc <= 1'b0;
      rpt_cor <= 1'b0;
    end else begin
      sum_unc <= unc_hold | unc_hit;
      sum_cor <= cor_hold | cor_hit;
      rpt_unc <= unc_hit & ~unc_hold;
      rpt_cor <= cor_hit & ~cor_hold;
    end
  end
endmodule

// File: rtl/ierr_report_ctrl.sv
module ierr_report_ctrl
  import ierr_pkg::*;
#(
  parameter int NERR = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NERR-1:0] err_evt,
  input  logic            reg_we,
  input  logic [2:0]      reg_addr,
  input  logic [NERR-1:0] reg_wdata,
  output logic [NERR-1:0] reg_rdata,
  output logic [2:0]      rpt_unc,
  output logic [2:0]      rpt_cor
);
  logic [NERR-1:0]          status, sev, inj_q;
  logic                     glb_en;
  logic [NFN-1:0][NERR-1:0] mask;
  logic [NFN-1:0]           clr_unc, clr_cor, sum_unc, sum_cor;

  ierr_regs #(.NERR(NERR)) u_regs (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .sum_unc(sum_unc), .sum_cor(sum_cor),
    .status(status), .sev(sev), .inj_q(inj_q), .glb_en(glb_en),
    .mask(mask), .clr_unc(clr_unc), .clr_cor(clr_cor)
  );

  for (genvar f = 0; f < NFN; f++) begin : g_view
    logic [NERR-1:0] evt_f;
    // Emulated errors only feed the bridge view.
    if (f == FN_BR) begin : g_br
      assign evt_f = err_evt | inj_q;
    end else begin : g_oth
      assign evt_f = err_evt;
    end
    ierr_fn_report #(.NERR(NERR)) u_fn (
      .clk(clk), .rst_n(rst_n), .evt(evt_f), .mask(mask[f]), .sev(sev),
      .glb_en(glb_en), .clr_unc(clr_unc[f]), .clr_cor(clr_cor[f]),
      .sum_unc(sum_unc[f]), .sum_cor(sum_cor[f]),
      .rpt_unc(rpt_unc[f]), .rpt_cor(rpt_cor[f])
    );
  end
endmodule

// File: rtl/ierr_report_chk.sv
module ierr_report_chk #(
  parameter int NERR = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic [NERR-1:0] err_evt,
  input logic            reg_we,
  input logic [2:0]      reg_addr,
  input logic [NERR-1:0] reg_wdata,
  input logic [2:0]      rpt_unc,
  input logic [2:0]      rpt_cor,
  input logic [NERR-1:0] status,
  input logic [2:0]      sum_unc,
  input logic [2:0]      sum_cor,
  input logic            glb_en
);
  logic past_ok;
  logic [2:0] sw_clr_unc, sw_clr_cor;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else past_ok <= 1'b1;
  end

  for (genvar f = 0; f < 3; f++) begin : g_clr
    assign sw_clr_unc[f] = reg_we && reg_addr == 3'd7 && reg_wdata[2*f];
    assign sw_clr_cor[f] = reg_we && reg_addr == 3'd7 && reg_wdata[2*f+1];
  end

  // R1: an event seen last cycle is logged now
  p_event_logged_r1: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> ((status & $past(err_evt)) == $past(err_evt)));

  // R5: a report pulse comes with its summary bit set
  p_pulse_sets_summary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((rpt_unc & ~sum_unc) == 3'b0) && ((rpt_cor & ~sum_cor) == 3'b0));

  // R6: a held, uncleared summary blocks a new report of its class
  p_sticky_suppress_r6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (((rpt_unc & $past(sum_unc) & ~$past(sw_clr_unc)) == 3'b0) &&
                 ((rpt_cor & $past(sum_cor) & ~$past(sw_clr_cor)) == 3'b0)));

  // R8: non-bridge views report only after a real detector event
  p_inject_bridge_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && (|{rpt_unc[2:1], rpt_cor[2:1]})) |-> $past(|err_evt));

  // R9: nothing reports while the global enable was off
  p_disabled_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && !$past(glb_en)) |-> (rpt_unc == 3'b0 && rpt_cor == 3'b0));
endmodule

bind ierr_report_ctrl ierr_report_chk #(.NERR(NERR)) u_chk (
  .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .reg_we(reg_we),
  .reg_addr(reg_addr), .reg_wdata(reg_wdata), .rpt_unc(rpt_unc),
  .rpt_cor(rpt_cor), .status(status), .sum_unc(sum_unc),
  .sum_cor(sum_cor), .glb_en(glb_en)
);

// File: tb/ierr_report_ctrl_bench.sv
module ierr_report_ctrl_bench;
  localparam int NERR = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NERR-1:0] err_evt = '0;
  logic            reg_we = 1'b0;
  logic [2:0]      reg_addr = '0;
  logic [NERR-1:0] reg_wdata = '0;
  logic [NERR-1:0] reg_rdata;
  logic [2:0]      rpt_unc, rpt_cor;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  ierr_report_ctrl #(.NERR(NERR)) u_ierr_report_ctrl (
    .clk(clk), .rst_n(rst_n), .err_evt(err_evt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .rpt_unc(rpt_unc), .rpt_cor(rpt_cor)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [NERR-1:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [NERR-1:0] d);
    reg_addr = a;
    #0.5;
    d = reg_rdata;
  endtask

  // Pulse events for one cycle; returns at the negedge after the sampling edge.
  task automatic evt(logic [NERR-1:0] e);
    @(negedge clk);
    err_evt = e;
    @(negedge clk);
    err_evt = '0;
  endtask

  task automatic t_reset();
    logic [NERR-1:0] d;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk("R10 reg", {16'h0, d}, 32'h0);
    end
    chk("R10 rpt", {26'h0, rpt_unc, rpt_cor}, 32'h0);
  endtask

  task automatic t_map();
    logic [NERR-1:0] d;
    wr(3'd4, 16'h1234); rd(3'd4, d); chk("R11 mask br", {16'h0, d}, 32'h1234);
    wr(3'd5, 16'hA5A5); rd(3'd5, d); chk("R11 mask nt", {16'h0, d}, 32'hA5A5);
    wr(3'd6, 16'h0F0F); rd(3'd6, d); chk("R11 mask dma", {16'h0, d}, 32'h0F0F);
    wr(3'd4, 16'h0); wr(3'd5, 16'h0); wr(3'd6, 16'h0);
    wr(3'd1, 16'h00F0); rd(3'd1, d); chk("R11 sev", {16'h0, d}, 32'h00F0);
  endtask

  task automatic t_disabled();
    logic [NERR-1:0] d;
    evt(16'h0008);
    chk("R9 no report", {26'h0, rpt_unc, rpt_cor}, 32'h0);
    rd(3'd0, d); chk("R1 logged while disabled", {16'h0, d}, 32'h0008);
    rd(3'd7, d); chk("R9 summary clear", {16'h0, d}, 32'h0);
    wr(3'd0, 16'h0000); rd(3'd0, d); chk("R2 zero write keeps", {16'h0, d}, 32'h0008);
    wr(3'd0, 16'h0008); rd(3'd0, d); chk("R2 w1c", {16'h0, d}, 32'h0);
    wr(3'd2, 16'h0001); rd(3'd2, d); chk("R11 ctrl", {16'h0, d}, 32'h0001);
  endtask

  task automatic t_route();
    logic [NERR-1:0] d;
    evt(16'h0020);
    chk("R3 unc routed", {29'h0, rpt_unc}, 32'h7);
    chk("R5 no cor", {29'h0, rpt_cor}, 32'h0);
    rd(3'd7, d); chk("R5 unc summaries", {16'h0, d}, 32'h15);
    @(negedge clk);
    chk("R5 single pulse", {29'h0, rpt_unc}, 32'h0);
    evt(16'h0002);
    chk("R6 other class reports", {29'h0, rpt_cor}, 32'h7);
    chk("R3 cor not unc", {29'h0, rpt_unc}, 32'h0);
    rd(3'd7, d); chk("R7 summary layout", {16'h0, d}, 32'h3F);
  endtask

  task automatic t_sticky();
    logic [NERR-1:0] d;
    evt(16'h0040);
    chk("R6 unc suppressed", {26'h0, rpt_unc, rpt_cor}, 32'h0);
    rd(3'd0, d); chk("R1 logged while sticky", {16'h0, d}[6], 32'h1);
    wr(3'd7, 16'h0001);
    rd(3'd7, d); chk("R7 clear bridge unc", {16'h0, d}, 32'h3E);
    evt(16'h0020);
    chk("R7 reopened bridge only", {29'h0, rpt_unc}, 32'h1);
    wr(3'd7, 16'h003F); wr(3'd0, 16'hFFFF);
    rd(3'd7, d); chk("R7 clear all", {16'h0, d}, 32'h0);
  endtask

  task automatic t_mask();
    evt(16'h0004 | 16'h0000);
    chk("R4 baseline cor", {29'h0, rpt_cor}, 32'h7);
    wr(3'd7, 16'h003F);
    wr(3'd5, 16'h0004);
    evt(16'h0004);
    chk("R4 nt masked only", {29'h0, rpt_cor}, 32'h5);
    wr(3'd5, 16'h0); wr(3'd7, 16'h003F); wr(3'd0, 16'hFFFF);
  endtask

  task automatic t_inject();
    logic [NERR-1:0] d;
    wr(3'd3, 16'h0080);
    rd(3'd3, d); chk("R8 inject reads zero", {16'h0, d}, 32'h0);
    @(negedge clk);
    chk("R8 bridge unc only", {26'h0, rpt_unc, rpt_cor}, 32'h08);
    rd(3'd0, d); chk("R8 injected logged", {16'h0, d}, 32'h0080);
    @(negedge clk);
    chk("R8 single shot", {26'h0, rpt_unc, rpt_cor}, 32'h0);
    wr(3'd7, 16'h003F); wr(3'd0, 16'hFFFF);
  endtask

  task automatic t_set_wins();
    logic [NERR-1:0] d;
    evt(16'h0001);
    wr(3'd7, 16'h003F);
    @(negedge clk);
    err_evt = 16'h0001; reg_we = 1'b1; reg_addr = 3'd0; reg_wdata = 16'h0001;
    @(negedge clk);
    err_evt = '0; reg_we = 1'b0;
    rd(3'd0, d); chk("R2 set wins over clear", {16'h0, d}, 32'h0001);
    // summary clear racing a new uncorrectable error
    evt(16'h0080);
    @(negedge clk);
    err_evt = 16'h0080; reg_we = 1'b1; reg_addr = 3'd7; reg_wdata = 16'h003F;
    @(negedge clk);
    err_evt = '0; reg_we = 1'b0;
    chk("R7 racing error reports", {29'h0, rpt_unc}, 32'h7);
    rd(3'd7, d); chk("R7 set wins summary", {16'h0, d}, 32'h15);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    t_reset();
    rst_n = 1'b1;
    t_reset();
    t_map();
    t_disabled();
    t_route();
    t_sticky();
    t_mask();
    t_inject();
    t_set_wins();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule